// File: doc/BRIEF.md
# E3 Frame Alignment Controller

This block takes a serial E3 receive bit stream, one bit per clock, and finds the frame alignment word in it. It can start at any bit offset. When the word first shows up, the block takes that bit position as a candidate frame boundary. It then checks for the word at the same position in the following frames. After the candidate is confirmed, the block stays in frame and tests the word once per frame. Occasional bit errors in the word are tolerated. A run of consecutive erred words sends the block back to searching.

The block drives two defect levels. The out-of-frame defect is high whenever the block is not in frame. The loss-of-frame defect is raised when the out-of-frame condition lasts for a programmed number of frame periods. A software control bit forces a reframe on its rising edge only. This raises both defects at once and restarts the search. While in frame, a one-cycle strobe marks the first payload bit of each frame, so downstream logic can count payload bits from it.

The block has three states. `ST_HUNT` searches every bit position. It moves to `ST_CONFIRM` when a candidate is found. `ST_CONFIRM` goes to `ST_SYNC` after enough confirmations, and back to `ST_HUNT` on a miss. `ST_SYNC` returns to `ST_HUNT` on an error run. A reframe edge moves any state to `ST_HUNT`.

Top module: `e3_frame_align`

## Requirements
- R1: While reset is applied, and before the first clock edge after it, `oof_o`=1, `lof_o`=0, `in_frame_o`=0 and `frame_start_o`=0.
- R2: In `ST_HUNT`, every bit position is examined. The alignment word is 1111010000, with the leftmost bit received first. The clock edge that samples its last bit fixes a candidate boundary, whatever the bit offset of the stream.
- R3: `in_frame_o` rises, and `oof_o` falls, on the edge that samples the last word bit in the second frame after the candidate. If the word is not exactly at the expected position in either of those two frames, the block returns to `ST_HUNT`.
- R4: In `ST_SYNC`, up to three consecutive erred words keep the block in frame. A single correct word resets the run, so scattered errors never cause a loss.
- R5: The fourth consecutive erred word drops `in_frame_o` and raises `oof_o` on the edge that samples its last bit. The block then hunts again.
- R6: `lof_o` rises on the LOF_FRAMES×FRAME_BITS-th consecutive clock edge at which the block is out of frame. This count starts at the first edge after reset, or at the loss edge.
- R7: `lof_o` is never high without `oof_o`. Both fall on the edge where `in_frame_o` rises.
- R8: On the edge that samples a 0-to-1 transition of `reframe_i`, the block goes to `ST_HUNT` from any state, and `oof_o` and `lof_o` are both high after that edge.
- R9: Holding `reframe_i` at 1, or taking it from 1 to 0, has no effect on alignment or defects.
- R10: `frame_start_o` is high for exactly one cycle per frame while in frame. It is high in the cycle that samples the bit following the alignment word, so strobes are FRAME_BITS cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit clock |
| rst_n_i | input | 1 | Asynchronous reset, active low |
| data_i | input | 1 | Serial receive data, one bit per clock |
| reframe_i | input | 1 | Software reframe control; its rising edge acts |
| oof_o | output | 1 | Out-of-frame defect level |
| lof_o | output | 1 | Loss-of-frame defect level |
| in_frame_o | output | 1 | High while in the maintenance state |
| frame_start_o | output | 1 | One-cycle strobe on the first payload bit of each frame |

## Verification
The checker tests four things on every cycle:
- a reframe edge raises both defects on the next cycle;
- loss-of-frame never appears without out-of-frame;
- acquiring frame leaves loss-of-frame low;
- the frame-start strobe is a single cycle and recurs exactly one frame period later while alignment holds.

Some behaviour can only be shown by the bench's scenarios. These are:
- the exact edge on which lock is declared, over a sweep of starting offsets;
- counting one to five consecutive erred words;
- a failed confirmation;
- the bit-exact timing of loss-of-frame;
- reframe edges hitting each state, while level holds and falling edges are shown to do nothing.

// File: rtl/e3fa_pkg.sv
package e3fa_pkg;

    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_CONFIRM = 2'd1,
        ST_SYNC    = 2'd2
    } e3fa_state_t;

endpackage

// File: rtl/e3fa_window.sv
// Sliding window over the last LEN received bits; flags the alignment word
// in the same cycle its final bit is presented.
module e3fa_window #(
    parameter int              LEN     = 10,
    parameter logic [LEN-1:0]  PATTERN = 10'b1111010000
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic bit_i,
    output logic hit_o
);

    logic [LEN-2:0] hist_q;
    logic [LEN-1:0] window;

    assign window = {hist_q, bit_i};
    assign hit_o  = (window == PATTERN);

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            hist_q <= '0;
        end else begin
            hist_q <= window[LEN-2:0];
        end
    end

endmodule

// File: rtl/e3fa_bitpos.sv
// Bit position within the frame. Position 0 is the first alignment bit.
// A realign request places the next cycle on the first payload bit.
module e3fa_bitpos #(
    parameter int FRAME_BITS = 1536,
    parameter int WORD_LEN   = 10
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic realign_i,
    output logic check_o,
    output logic payload0_o
);

    localparam int             PW        = $clog2(FRAME_BITS);
    localparam logic [PW-1:0]  POS_LAST  = PW'(FRAME_BITS - 1);
    localparam logic [PW-1:0]  POS_CHECK = PW'(WORD_LEN - 1);
    localparam logic [PW-1:0]  POS_PAY0  = PW'(WORD_LEN);

    logic [PW-1:0] pos_q;

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            pos_q <= '0;
        end else if (realign_i) begin
            pos_q <= POS_PAY0;
        end else if (pos_q == POS_LAST) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_q + 1'b1;
        end
    end

    assign check_o    = (pos_q == POS_CHECK);
    assign payload0_o = (pos_q == POS_PAY0);

endmodule

// File: rtl/e3fa_lof_timer.sv
// Counts clock edges spent out of frame and raises the loss-of-frame level.
module e3fa_lof_timer #(
    parameter int LIMIT = 36864
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic lock_i,
    input  logic force_i,
    output logic lof_o
);

    localparam int            CW      = $clog2(LIMIT);
    localparam logic [CW-1:0] CNT_END = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;
    logic          lof_q;

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            cnt_q <= '0;
            lof_q <= 1'b0;
        end else if (lock_i) begin
            cnt_q <= '0;
            lof_q <= 1'b0;
        end else if (force_i) begin
            cnt_q <= '0;
            lof_q <= 1'b1;
        end else if (!lof_q) begin
            if (cnt_q == CNT_END) begin
                lof_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign lof_o = lof_q;

endmodule

// File: rtl/e3fa_fsm.sv
// Hunt / confirm / sync controller with the reframe edge detector.
module e3fa_fsm
    import e3fa_pkg::*;
#(
    parameter int OOF_FRAMES    = 4,
    parameter int VERIFY_FRAMES = 2
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic hit_i,
    input  logic check_i,
    input  logic payload0_i,
    input  logic reframe_i,
    output logic realign_o,
    output logic in_frame_o,
    output logic oof_o,
    output logic frame_start_o,
    output logic lock_next_o,
    output logic force_o
);

    localparam int            TMAX     = (OOF_FRAMES > VERIFY_FRAMES) ? OOF_FRAMES : VERIFY_FRAMES;
    localparam int            TW       = $clog2(TMAX + 1);
    localparam logic [TW-1:0] VER_LAST = TW'(VERIFY_FRAMES - 1);
    localparam logic [TW-1:0] ERR_LAST = TW'(OOF_FRAMES - 1);

    e3fa_state_t   state_q, state_d;
    logic [TW-1:0] tally_q, tally_d;
    logic          rf_q;
    logic          rf_rise;

    assign rf_rise = reframe_i & ~rf_q;

    // State register
    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            state_q <= ST_HUNT;
            tally_q <= '0;
            rf_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            tally_q <= tally_d;
            rf_q    <= reframe_i;
        end
    end

    // Next state
    always_comb begin
        state_d   = state_q;
        tally_d   = tally_q;
        realign_o = 1'b0;
        if (rf_rise) begin
            state_d = ST_HUNT;
            tally_d = '0;
        end else begin
            unique case (state_q)
                ST_HUNT: begin
                    if (hit_i) begin
                        state_d   = ST_CONFIRM;
                        tally_d   = '0;
                        realign_o = 1'b1;
                    end
                end
                ST_CONFIRM: begin
                    if (check_i) begin
                        if (!hit_i) begin
                            state_d = ST_HUNT;
                            tally_d = '0;
                        end else if (tally_q == VER_LAST) begin
                            state_d = ST_SYNC;
                            tally_d = '0;
                        end else begin
                            tally_d = tally_q + 1'b1;
                        end
                    end
                end
                ST_SYNC: begin
                    if (check_i) begin
                        if (hit_i) begin
                            tally_d = '0;
                        end else if (tally_q == ERR_LAST) begin
                            state_d = ST_HUNT;
                            tally_d = '0;
                        end else begin
                            tally_d = tally_q + 1'b1;
                        end
                    end
                end
                default: begin
                    state_d = ST_HUNT;
                    tally_d = '0;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        in_frame_o    = (state_q == ST_SYNC);
        oof_o         = (state_q != ST_SYNC);
        frame_start_o = (state_q == ST_SYNC) && payload0_i;
        lock_next_o   = (state_d == ST_SYNC);
        force_o       = rf_rise;
    end

endmodule

// File: rtl/e3_frame_align.sv
module e3_frame_align #(
    parameter int                  FRAME_BITS    = 1536,
    parameter int                  FAW_LEN       = 10,
    parameter logic [FAW_LEN-1:0]  FAW_PATTERN   = 10'b1111010000,
    parameter int                  OOF_FRAMES    = 4,
    parameter int                  VERIFY_FRAMES = 2,
    parameter int                  LOF_FRAMES    = 24
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic data_i,
    input  logic reframe_i,
    output logic oof_o,
    output logic lof_o,
    output logic in_frame_o,
    output logic frame_start_o
);

    localparam int LOF_LIMIT = LOF_FRAMES * FRAME_BITS;

    logic hit, check, payload0, realign, lock_next, force_rf;

    e3fa_window #(
        .LEN     (FAW_LEN),
        .PATTERN (FAW_PATTERN)
    ) u_window (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .bit_i   (data_i),
        .hit_o   (hit)
    );

    e3fa_bitpos #(
        .FRAME_BITS (FRAME_BITS),
        .WORD_LEN   (FAW_LEN)
    ) u_bitpos (
        .clk_i      (clk_i),
        .rst_n_i    (rst_n_i),
        .realign_i  (realign),
        .check_o    (check),
        .payload0_o (payload0)
    );

    e3fa_fsm #(
        .OOF_FRAMES    (OOF_FRAMES),
        .VERIFY_FRAMES (VERIFY_FRAMES)
    ) u_fsm (
        .clk_i         (clk_i),
        .rst_n_i       (rst_n_i),
        .hit_i         (hit),
        .check_i       (check),
        .payload0_i    (payload0),
        .reframe_i     (reframe_i),
        .realign_o     (realign),
        .in_frame_o    (in_frame_o),
        .oof_o         (oof_o),
        .frame_start_o (frame_start_o),
        .lock_next_o   (lock_next),
        .force_o       (force_rf)
    );

    e3fa_lof_timer #(
        .LIMIT (LOF_LIMIT)
    ) u_lof (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .lock_i  (lock_next),
        .force_i (force_rf),
        .lof_o   (lof_o)
    );

endmodule

// File: rtl/e3fa_checker.sv
module e3fa_checker #(
    parameter int FRAME_BITS = 1536
) (
    input logic clk_i,
    input logic rst_n_i,
    input logic reframe_i,
    input logic oof_o,
    input logic lof_o,
    input logic in_frame_o,
    input logic frame_start_o
);

    localparam int            GW       = $clog2(FRAME_BITS + 1);
    localparam logic [GW-1:0] GAP_LAST = GW'(FRAME_BITS - 1);
    localparam logic [GW-1:0] GAP_MAX  = GW'(FRAME_BITS);

    logic [GW-1:0] gap_q;
    logic          armed_q;

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            gap_q   <= '0;
            armed_q <= 1'b0;
        end else begin
            if (frame_start_o) begin
                gap_q <= '0;
            end else if (gap_q != GAP_MAX) begin
                gap_q <= gap_q + 1'b1;
            end
            armed_q <= in_frame_o && (frame_start_o || armed_q);
        end
    end

    AST_REFRAME_DEFECTS: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $rose(reframe_i) |=> (oof_o && lof_o && !in_frame_o)); // R8
    AST_LOF_WITH_OOF: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        lof_o |-> oof_o); // R7
    AST_LOCK_CLEARS_LOF: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $rose(in_frame_o) |-> !lof_o); // R7
    AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        frame_start_o |=> !frame_start_o); // R10
    AST_STROBE_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (frame_start_o && armed_q) |-> (gap_q == GAP_LAST)); // R10

endmodule

bind e3_frame_align e3fa_checker #(
    .FRAME_BITS (FRAME_BITS)
) u_check (
    .clk_i         (clk_i),
    .rst_n_i       (rst_n_i),
    .reframe_i     (reframe_i),
    .oof_o         (oof_o),
    .lof_o         (lof_o),
    .in_frame_o    (in_frame_o),
    .frame_start_o (frame_start_o)
);

// File: tb/sim_e3_frame_align.sv
module sim_e3_frame_align;

    localparam int CLK_PERIOD = 10;
    localparam int FB         = 64;
    localparam int FL         = 10;
    localparam int OOFN       = 4;
    localparam int LOFF       = 3;
    localparam int LIMIT      = LOFF * FB;
    localparam logic [FL-1:0] FAW = 10'b1111010000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic din = 1'b0;
    logic rf = 1'b0;
    logic oof, lof, inf, fs;

    int n_checks = 0;
    int n_fail = 0;

    logic s_oof, s_lof, s_inf, s_fs;
    logic a8_inf, a8_lof, a9_inf, a9_oof, a9_lof;
    logic r_inf, r_oof, r_lof;
    int   fs_cnt, fs_at;

    e3_frame_align #(
        .FRAME_BITS (FB),
        .FAW_LEN    (FL),
        .FAW_PATTERN(FAW),
        .OOF_FRAMES (OOFN),
        .VERIFY_FRAMES(2),
        .LOF_FRAMES (LOFF)
    ) u0 (
        .clk_i         (clk),
        .rst_n_i       (rst_n),
        .data_i        (din),
        .reframe_i     (rf),
        .oof_o         (oof),
        .lof_o         (lof),
        .in_frame_o    (inf),
        .frame_start_o (fs)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Called just after a falling edge; drives one bit, samples after the rising edge.
    task automatic send_bit(input logic b);
        din = b;
        @(posedge clk);
        #(CLK_PERIOD/4);
        s_oof = oof; s_lof = lof; s_inf = inf; s_fs = fs;
        @(negedge clk);
    endtask

    function automatic logic pay(input int pat, input int i);
        case (pat)
            1:       return logic'(i % 2);
            2:       return logic'(i % 3 == 0);
            default: return 1'b0;
        endcase
    endfunction

    task automatic send_frame(input logic erred, input int pat, input int rf_at, input logic rf_val);
        logic b;
        fs_cnt = 0;
        fs_at = -1;
        for (int i = 0; i < FB; i++) begin
            if (i < FL) b = FAW[FL-1-i] ^ (erred && i == 0);
            else        b = pay(pat, i);
            if (i == rf_at) rf = rf_val;
            send_bit(b);
            if (s_fs) begin fs_cnt++; fs_at = i; end
            if (i == 8) begin a8_inf = s_inf; a8_lof = s_lof; end
            if (i == 9) begin a9_inf = s_inf; a9_oof = s_oof; a9_lof = s_lof; end
            if (i == rf_at) begin r_inf = s_inf; r_oof = s_oof; r_lof = s_lof; end
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; din = 1'b0; rf = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic lock_up(input int pat);
        do_reset();
        repeat (3) send_frame(1'b0, pat, -1, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int offs[6] = '{0, 1, 5, 13, 37, 63};
        logic [9:0] scat = 10'b1011101110;

        // R1: reset values
        do_reset();
        chk("R1 oof", oof, 1); chk("R1 lof", lof, 0);
        chk("R1 in_frame", inf, 0); chk("R1 strobe", fs, 0);

        // R2/R3/R10: acquisition at a sweep of bit offsets
        foreach (offs[k]) begin
            do_reset();
            repeat (offs[k]) send_bit(1'b0);
            send_frame(1'b0, k % 3, -1, 1'b0);
            chk("R2 candidate only", a9_inf, 0);
            send_frame(1'b0, k % 3, -1, 1'b0);
            chk("R3 not yet locked", a9_inf, 0);
            send_frame(1'b0, k % 3, -1, 1'b0);
            chk("R3 before last bit", a8_inf, 0);
            chk("R2 lock at offset", a9_inf, 1);
            chk("R3 oof cleared", a9_oof, 0);
            chk("R6 lof before lock", a8_lof, int'(offs[k] + 2*FB + 9 >= LIMIT));
            chk("R7 lof cleared on lock", a9_lof, 0);
            chk("R10 strobe count", fs_cnt, 1);
            chk("R10 strobe position", fs_at, 9);
            send_frame(1'b0, k % 3, -1, 1'b0);
            chk("R10 strobe count next", fs_cnt, 1);
            chk("R10 strobe position next", fs_at, 9);
        end

        // R3: a miss during confirmation restarts the hunt
        do_reset();
        send_frame(1'b0, 1, -1, 1'b0);
        send_frame(1'b1, 1, -1, 1'b0);
        chk("R3 miss in confirm", a9_inf, 0);
        send_frame(1'b0, 1, -1, 1'b0);
        send_frame(1'b0, 1, -1, 1'b0);
        chk("R3 relock needs three", a9_inf, 0);
        send_frame(1'b0, 1, -1, 1'b0);
        chk("R3 relock", a9_inf, 1);

        // R4/R5: consecutive error runs of length 1..5
        for (int n = 1; n <= 5; n++) begin
            lock_up(n % 3);
            for (int kk = 1; kk <= n; kk++) begin
                send_frame(1'b1, n % 3, -1, 1'b0);
                chk(kk < OOFN ? "R4 run kept" : "R5 run lost", a9_inf, int'(kk < OOFN));
                if (kk == OOFN) chk("R5 oof raised", a9_oof, 1);
            end
            if (n < OOFN) begin
                send_frame(1'b0, n % 3, -1, 1'b0);
                chk("R4 good word", a9_inf, 1);
                repeat (OOFN - 1) begin
                    send_frame(1'b1, n % 3, -1, 1'b0);
                    chk("R4 run restarted", a9_inf, 1);
                end
            end else begin
                send_frame(1'b0, n % 3, -1, 1'b0);
                send_frame(1'b0, n % 3, -1, 1'b0);
                chk("R5 hunting after loss", a9_inf, 0);
                send_frame(1'b0, n % 3, -1, 1'b0);
                chk("R5 relocked", a9_inf, 1);
            end
        end

        // R4: scattered errors never lose alignment
        lock_up(2);
        for (int i = 9; i >= 0; i--) begin
            send_frame(scat[i], 2, -1, 1'b0);
            chk("R4 scattered", a9_inf, 1);
        end

        // R6: loss of frame timing from reset
        do_reset();
        repeat (LIMIT - 1) send_bit(1'b0);
        chk("R6 lof just before limit", s_lof, 0);
        send_bit(1'b0);
        chk("R6 lof at limit", s_lof, 1);
        chk("R7 oof with lof", s_oof, 1);

        // R6/R7: loss of frame timing after a loss, then lock clears both
        lock_up(0);
        repeat (OOFN) send_frame(1'b1, 0, -1, 1'b0);
        repeat (LIMIT - 1 - (1 + FB - FL)) send_bit(1'b0);
        chk("R6 lof after loss, before limit", s_lof, 0);
        send_bit(1'b0);
        chk("R6 lof after loss, at limit", s_lof, 1);
        send_frame(1'b0, 0, -1, 1'b0);
        send_frame(1'b0, 0, -1, 1'b0);
        chk("R7 lof held in confirm", a9_lof, 1);
        send_frame(1'b0, 0, -1, 1'b0);
        chk("R7 lof cleared", a9_lof, 0);
        chk("R7 oof cleared", a9_oof, 0);

        // R8/R9: reframe from sync, hold high, then release
        lock_up(1);
        send_frame(1'b0, 1, 30, 1'b1);
        chk("R8 in_frame dropped", r_inf, 0);
        chk("R8 oof forced", r_oof, 1);
        chk("R8 lof forced", r_lof, 1);
        send_frame(1'b0, 1, -1, 1'b0);
        chk("R9 held high hunting", a9_inf, 0);
        send_frame(1'b0, 1, -1, 1'b0);
        send_frame(1'b0, 1, -1, 1'b0);
        chk("R9 held high relock", a9_inf, 1);
        chk("R9 held high lof clear", a9_lof, 0);
        send_frame(1'b0, 1, 20, 1'b0);
        chk("R9 falling edge ignored", r_inf, 1);
        chk("R9 falling edge lof", r_lof, 0);
        chk("R9 strobe kept", fs_cnt, 1);
        send_frame(1'b0, 1, -1, 1'b0);
        chk("R9 still in frame", a9_inf, 1);

        // R8: reframe while hunting raises lof at once
        do_reset();
        send_frame(1'b1, 0, 5, 1'b1);
        chk("R8 hunt lof forced", r_lof, 1);
        chk("R8 hunt oof", r_oof, 1);

        // R8: reframe while confirming restarts the search
        do_reset();
        send_frame(1'b0, 2, -1, 1'b0);
        send_frame(1'b0, 2, 20, 1'b1);
        chk("R8 confirm lof forced", r_lof, 1);
        send_frame(1'b0, 2, -1, 1'b0);
        chk("R8 confirm restarted", a9_inf, 0);
        send_frame(1'b0, 2, -1, 1'b0);
        send_frame(1'b0, 2, -1, 1'b0);
        chk("R8 confirm relock", a9_inf, 1);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule